// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the sequence of column addresses that a memory controller walks through during one read or write burst to a synchronous DRAM. A one-cycle start pulse captures a start column, a burst length code and an ordering bit. From the following cycle on, the block presents one column address per accepted beat on a valid/ready stream, together with a flag on the final beat.

Short bursts of 2, 4 or 8 beats stay inside the aligned group that holds the start column. The low bits either count upward and wrap, or are XORed with the beat index. The bits above the group never change. The full-page setting walks all columns upward from the start, wrapping at the top, and runs until a stop request ends it. The controller that drives the DRAM pins, counts CAS latency and times the data path sits around this block. A new start pulse abandons the current burst at any time.

Stream rules: a beat is accepted on a clock edge where `valid_o` and `ready_i` are both high. While `valid_o` is high and `ready_i` is low, the column and last flag hold steady. A stop request or a start pulse takes effect whatever the state of `ready_i`.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is applied and after it, `valid_o`, `last_o` and `err_o` are low until the first start pulse.
- R2: A start pulse makes `valid_o` high on the next cycle with `col_o` equal to the start column. Without a start pulse an idle block never raises `valid_o`.
- R3: Length code 3'b000, 3'b001, 3'b010 and 3'b011 gives exactly 1, 2, 4 and 8 accepted beats. Column bits above the group (bit 1 and up, bit 2 and up, bit 3 and up) keep the start value.
- R4: With ordering bit 0, beat i has low group bits equal to (start + i) mod length.
- R5: With ordering bit 1, beat i has low group bits equal to start XOR i.
- R6: Length code 3'b111 with ordering bit 0 (full page) gives beat i = (start + i) mod 512. It never ends by itself.
- R7: `last_o` is high exactly on the final beat of a finite burst. After that beat is accepted, `valid_o` goes low.
- R8: When `stop_i` is high while `valid_o` is high, `last_o` is high in that cycle and `valid_o` is low on the next cycle, whatever the value of `ready_i`.
- R9: While `valid_o` is high and `ready_i` is low, with no stop and no start, `valid_o` and `col_o` hold their values.
- R10: A start pulse during an active burst drops it. The next cycle shows the new burst's first beat. A start wins over a stop in the same cycle.
- R11: Length codes 3'b100, 3'b101 and 3'b110, or 3'b111 with ordering bit 1, give a single beat at the start column and set `err_o`. `err_o` stays high until reset, and valid codes never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse, captures the burst setup |
| start_col_i | input | 9 | Start column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Ordering: 0 add-and-wrap, 1 XOR |
| stop_i | input | 1 | Ends the current burst after this beat |
| ready_i | input | 1 | Consumer accepts the current beat |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of the burst |
| err_o | output | 1 | Sticky illegal-setup flag |

## Verification
Every one of the 512 start columns is swept for each finite length under both orderings. This catches a mapper that lets a carry leak into the fixed upper bits: it would step 7→8 instead of wrapping to 0. It also catches an XOR order built as a reversed count. A wrong beat counter shows up as an extra or missing beat, or as `last_o` on the wrong beat. A full-page run starts near the top column and runs past 512 beats, so a design that stops or fails to wrap at 511 is caught. Stop during a stall, a restart in mid-burst, a start and stop in the same cycle, and the illegal codes confirm the priority rules and that the error flag stays set.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

endpackage

// File: rtl/col_seq_decode.sv
module col_seq_decode
  import col_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic             bad_o
);

  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    ilv_o  = ilv_i;
    bad_o  = 1'b0;
    case (len_code_e'(code_i))
      LEN_1:    mask_o = COL_W'(0);
      LEN_2:    mask_o = COL_W'(1);
      LEN_4:    mask_o = COL_W'(3);
      LEN_8:    mask_o = COL_W'(7);
      LEN_PAGE: begin
        if (order_e'(ilv_i) == ORD_ILV) begin
          bad_o = 1'b1;
        end else begin
          mask_o = ALL_ONES;
          full_o = 1'b1;
        end
      end
      default:  bad_o = 1'b1;
    endcase
    if (bad_o) begin
      ilv_o = 1'b0;
    end
  end

endmodule

// File: rtl/col_seq_ctrl.sv
module col_seq_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] dec_mask_i,
  input  logic             dec_full_i,
  input  logic             dec_ilv_i,
  input  logic             dec_bad_i,
  input  logic             stop_i,
  input  logic             ready_i,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] cnt_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);

  logic full_q;
  logic final_beat;
  logic accept;

  // a finite burst ends once the beat index reaches the group mask
  assign final_beat = !full_q && (cnt_o == mask_o);
  assign accept     = valid_o && ready_i;
  assign last_o     = valid_o && (final_beat || stop_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o  <= '0;
      mask_o  <= '0;
      ilv_o   <= 1'b0;
      full_q  <= 1'b0;
      cnt_o   <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else if (start_i) begin
      base_o  <= col_i;
      mask_o  <= dec_mask_i;
      ilv_o   <= dec_ilv_i;
      full_q  <= dec_full_i;
      cnt_o   <= '0;
      valid_o <= 1'b1;
      if (dec_bad_i) begin
        err_o <= 1'b1;
      end
    end else if (valid_o && stop_i) begin
      valid_o <= 1'b0;
    end else if (accept) begin
      if (final_beat) begin
        valid_o <= 1'b0;
      end else begin
        cnt_o <= cnt_o + COL_W'(1);
      end
    end
  end

endmodule

// File: rtl/col_seq_map.sv
module col_seq_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] sum;

  assign sum = base_i + cnt_i;

  // per bit: outside the group keep the start bit, inside pick add or XOR
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (ilv_i ? (base_i[b] ^ cnt_i[b]) : sum[b])
                                : base_i[b];
  end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  input  logic             ready_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_ilv;
  logic             dec_bad;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic [COL_W-1:0] cnt_q;

  col_seq_decode #(.COL_W(COL_W)) u_decode (
    .code_i (len_code_i),
    .ilv_i  (ilv_i),
    .mask_o (dec_mask),
    .full_o (dec_full),
    .ilv_o  (dec_ilv),
    .bad_o  (dec_bad)
  );

  col_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .col_i      (start_col_i),
    .dec_mask_i (dec_mask),
    .dec_full_i (dec_full),
    .dec_ilv_i  (dec_ilv),
    .dec_bad_i  (dec_bad),
    .stop_i     (stop_i),
    .ready_i    (ready_i),
    .base_o     (base_q),
    .mask_o     (mask_q),
    .ilv_o      (ilv_q),
    .cnt_o      (cnt_q),
    .valid_o    (valid_o),
    .last_o     (last_o),
    .err_o      (err_o)
  );

  col_seq_map #(.COL_W(COL_W)) u_map (
    .base_i (base_q),
    .mask_i (mask_q),
    .cnt_i  (cnt_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

endmodule

// File: rtl/col_seq_sva.sv
module col_seq_sva #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic             ready_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o
);

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> !valid_o);

  assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && last_o && !start_i) |=> !valid_o);

  assert_stop_marks_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && stop_i) |-> last_o);

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !stop_i && !start_i) |=> (valid_o && $stable(col_o)));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

bind sdram_col_seq col_seq_sva #(.COL_W(COL_W)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .stop_i  (stop_i),
  .ready_i (ready_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .last_o  (last_o),
  .err_o   (err_o)
);

// File: tb/sdram_col_seq_tb.sv
module sdram_col_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [8:0] start_col_i;
  logic [2:0] len_code_i;
  logic       ilv_i;
  logic       stop_i;
  logic       ready_i;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;
  logic       err_o;

  int n_cmp  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sdram_col_seq #(.COL_W(9)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .ilv_i       (ilv_i),
    .stop_i      (stop_i),
    .ready_i     (ready_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <=150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(int c, int code, int ilv, int i);
    int n;
    if (code == 7 && ilv == 0) return (c + i) % 512;
    if (code > 3) return c;
    n = 1 << code;
    if (ilv != 0) return c ^ i;
    return (c & ~(n - 1)) | ((c + i) & (n - 1));
  endfunction

  function automatic int beats_of(int code);
    return (code <= 3) ? (1 << code) : 1;
  endfunction

  // drive a start pulse at the current negedge, return at the next negedge
  task automatic issue(input int c, input int code, input int ilv);
    start_i     = 1'b1;
    start_col_i = 9'(c);
    len_code_i  = 3'(code);
    ilv_i       = 1'(ilv);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // check a finite burst whose first beat is visible now
  task automatic check_beats(input int c, input int code, input int ilv, input bit stall);
    int n;
    n = beats_of(code);
    for (int i = 0; i < n; i++) begin
      if (stall && (i % 3 == 1)) begin
        ready_i = 1'b0;
        #1;
        chk("R9 stall valid", int'(valid_o), 1);
        chk("R9 stall col", int'(col_o), exp_col(c, code, ilv, i));
        @(negedge clk);
      end
      ready_i = 1'b1;
      #1;
      chk("R2 valid", int'(valid_o), 1);
      chk((ilv != 0) ? "R5 xor col" : "R4 R3 add col", int'(col_o), exp_col(c, code, ilv, i));
      chk("R7 last", int'(last_o), (i == n - 1) ? 1 : 0);
      @(negedge clk);
    end
    #1;
    chk("R3 R7 burst ended", int'(valid_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 0; start_col_i = 0; len_code_i = 0;
    ilv_i = 0; stop_i = 0; ready_i = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(valid_o), 0);
    chk("R1 reset last", int'(last_o), 0);
    chk("R1 reset err", int'(err_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R2 idle no beats", int'(valid_o), 0);
    chk("R1 err after reset", int'(err_o), 0);

    // R3 R4 R5: full sweep of start columns, lengths and orders
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int c = 0; c < 512; c++) begin
          issue(c, code, ilv);
          check_beats(c, code, ilv, (c % 5) == 0);
        end
    chk("R11 no error from valid codes", int'(err_o), 0);

    // R6 R8: full page across the top column, then stop
    issue(509, 7, 0);
    for (int i = 0; i < 600; i++) begin
      #1;
      chk("R6 page col", int'(col_o), (509 + i) % 512);
      chk("R6 page no last", int'(last_o), 0);
      @(negedge clk);
    end
    stop_i = 1'b1;
    #1;
    chk("R8 stop last", int'(last_o), 1);
    chk("R8 stop col", int'(col_o), (509 + 600) % 512);
    @(negedge clk);
    stop_i = 1'b0;
    #1;
    chk("R8 ended after stop", int'(valid_o), 0);

    // R8: stop during a stall ends an 8-beat XOR burst
    @(negedge clk);
    issue(45, 3, 1);
    @(negedge clk);
    ready_i = 1'b0;
    stop_i  = 1'b1;
    #1;
    chk("R8 stall stop col", int'(col_o), 45 ^ 1);
    chk("R8 stall stop last", int'(last_o), 1);
    @(negedge clk);
    stop_i  = 1'b0;
    ready_i = 1'b1;
    #1;
    chk("R8 stall stop ended", int'(valid_o), 0);

    // R10: restart in mid burst
    @(negedge clk);
    issue(10, 3, 0);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R10 pre-restart col", int'(col_o), exp_col(10, 3, 0, i));
      @(negedge clk);
    end
    issue(100, 2, 1);
    check_beats(100, 2, 1, 1'b0);

    // R10: start and stop together, start wins
    @(negedge clk);
    issue(300, 7, 0);
    @(negedge clk);
    stop_i = 1'b1;
    issue(7, 0, 0);
    stop_i = 1'b0;
    check_beats(7, 0, 0, 1'b0);

    // R11: illegal codes
    @(negedge clk);
    issue(77, 5, 0);
    #1;
    chk("R11 err set", int'(err_o), 1);
    chk("R11 single beat col", int'(col_o), 77);
    chk("R11 single beat last", int'(last_o), 1);
    @(negedge clk);
    #1;
    chk("R11 single beat ended", int'(valid_o), 0);
    @(negedge clk);
    issue(200, 2, 0);
    check_beats(200, 2, 0, 1'b0);
    chk("R11 err sticky", int'(err_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 err cleared", int'(err_o), 0);
    @(negedge clk);
    issue(131, 7, 1);
    check_beats(131, 7, 1, 1'b0);
    chk("R11 page with xor err", int'(err_o), 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule